// File: doc/BRIEF.md
# Seconds-Counting Real-Time Clock with Alarm

This block is a real-time clock peripheral that sits behind a single APB-style slave port. A 32-bit seconds count advances once every `CLK_HZ` cycles of the block clock, driven by an internal prescaler that produces a one-cycle enable. Software may overwrite the count at any time, program an alarm value, and receive an interrupt when the count arrives at that value. The interrupt has a one-bit enable, separate raw and enabled status views, and a clear port that responds to any write.

Reads return data in the access phase of the transfer with no wait states. Writes take effect at the clock edge that ends the access phase. A short block of constant identification bytes sits at the top of the 4 KiB window so that software can find the peripheral.

Top module: `sec_rtc`

## Requirements
- R1: While `rst` is high and after its release, the count, alarm value, load readback, interrupt enable and raw status all read 0, and `irq` is 0.
- R2: The count rises by exactly one on each prescaler enable. The enable fires on the `CLK_HZ`-th rising edge after reset is released and then on every `CLK_HZ`-th edge after that. The count does not change between enables.
- R3: A write to offset 0x08 makes the count equal to the written value at the next edge, overriding a coincident enable. Counting then resumes from that value, and offset 0x08 reads back the last value written to it.
- R4: The count wraps from 0xFFFFFFFF to 0, and an alarm value of 0 fires on that wrap.
- R5: Raw status (offset 0x14, bit 0) becomes 1 when an enable advances the count to the alarm value held at offset 0x04.
- R6: A write to offset 0x04 or 0x08 that leaves the count equal to the alarm value sets raw status at that same edge.
- R7: Offset 0x10 keeps only bit 0 of written data, and reads return that bit with bits 31:1 at 0.
- R8: A write of any data to offset 0x1C clears raw status. If the same edge also sets the alarm, the set wins.
- R9: `irq` equals raw status AND the enable bit, and offset 0x18 reads that same value in bit 0.
- R10: Offset 0x0C always reads 1. Writes to 0x0C, 0x00, 0x14 and 0x18 change no state.
- R11: Word offsets 0xFE0 to 0xFFC read, in address order, 0x31, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R12: Offset 0x1C and every unmapped offset read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the prescaler reference |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase of a transfer |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 12 | Byte address within the window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| irq | output | 1 | Alarm interrupt, level high |

## Verification
The checker watches properties on every cycle: the count moves only by a single step on an enable or by a load, a load lands its data exactly, a lone clear empties raw status, and the control, enable and enabled-status reads stay consistent with the interrupt pin. Some behaviour spans many cycles or depends on values chosen by software. This includes the exact prescaler period, the alarm on wraparound, the immediate alarm from a load or match write, the precedence of set over clear, and the identification bytes. Only the bench scenarios can show these, by comparing every read against a model built from the requirements while random register traffic runs.

// File: rtl/sec_rtc_pkg.sv
package sec_rtc_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int ID_N   = 8;

    typedef enum logic [2:0] {
        SEL_COUNT = 3'd0,
        SEL_MATCH = 3'd1,
        SEL_LOAD  = 3'd2,
        SEL_CTRL  = 3'd3,
        SEL_MASK  = 3'd4,
        SEL_RAW   = 3'd5,
        SEL_MIS   = 3'd6,
        SEL_CLR   = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic              load_we;
        logic              match_we;
        logic              mask_we;
        logic              clr_we;
        logic [DATA_W-1:0] data;
    } rtc_wr_t;

    typedef struct packed {
        logic [DATA_W-1:0] count;
        logic [DATA_W-1:0] match;
        logic [DATA_W-1:0] load;
        logic              mask;
        logic              raw;
    } rtc_state_t;

    function automatic logic [7:0] id_byte(input logic [2:0] idx);
        logic [7:0] b;
        case (idx)
            3'd0:    b = 8'h31;
            3'd1:    b = 8'h10;
            3'd2:    b = 8'h14;
            3'd3:    b = 8'h00;
            3'd4:    b = 8'h0D;
            3'd5:    b = 8'hF0;
            3'd6:    b = 8'h05;
            default: b = 8'hB1;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/sec_rtc_prescaler.sv
module sec_rtc_prescaler #(
    parameter int CLK_HZ = 50_000_000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int DIV_W = (CLK_HZ > 2) ? $clog2(CLK_HZ) : 1;
    localparam logic [DIV_W-1:0] LAST = DIV_W'(CLK_HZ - 1);

    logic [DIV_W-1:0] div_q;

    assign tick = (div_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
        end else if (tick) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end
endmodule

// File: rtl/sec_rtc_bus.sv
module sec_rtc_bus
    import sec_rtc_pkg::*;
(
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    input  rtc_state_t        st,
    output rtc_wr_t           wr,
    output logic [DATA_W-1:0] prdata
);
    logic     in_regs;
    logic     in_id;
    logic     wr_go;
    reg_sel_e sel;

    assign in_regs = (paddr[ADDR_W-1:5] == '0);
    assign in_id   = (paddr[ADDR_W-1:5] == '1);
    assign sel     = reg_sel_e'(paddr[4:2]);
    assign wr_go   = psel && penable && pwrite && in_regs;

    always_comb begin
        wr          = '0;
        wr.data     = pwdata;
        wr.load_we  = wr_go && (sel == SEL_LOAD);
        wr.match_we = wr_go && (sel == SEL_MATCH);
        wr.mask_we  = wr_go && (sel == SEL_MASK);
        wr.clr_we   = wr_go && (sel == SEL_CLR);
    end

    always_comb begin
        prdata = '0;
        if (in_id) begin
            prdata = {{(DATA_W-8){1'b0}}, id_byte(paddr[4:2])};
        end else if (in_regs) begin
            case (sel)
                SEL_COUNT: prdata = st.count;
                SEL_MATCH: prdata = st.match;
                SEL_LOAD:  prdata = st.load;
                SEL_CTRL:  prdata = DATA_W'(1);
                SEL_MASK:  prdata = {{(DATA_W-1){1'b0}}, st.mask};
                SEL_RAW:   prdata = {{(DATA_W-1){1'b0}}, st.raw};
                SEL_MIS:   prdata = {{(DATA_W-1){1'b0}}, st.raw & st.mask};
                default:   prdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/sec_rtc_core.sv
module sec_rtc_core
    import sec_rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  rtc_wr_t    wr,
    output rtc_state_t st
);
    logic [DATA_W-1:0] cnt_n;
    logic [DATA_W-1:0] mat_n;
    logic              hit;

    always_comb begin
        if (wr.load_we)   cnt_n = wr.data;
        else if (tick)    cnt_n = st.count + 1'b1;
        else              cnt_n = st.count;
        mat_n = wr.match_we ? wr.data : st.match;
        hit   = (wr.load_we || wr.match_we || tick) && (cnt_n == mat_n);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            st.count <= cnt_n;
            st.match <= mat_n;
            if (wr.load_we) st.load <= wr.data;
            if (wr.mask_we) st.mask <= wr.data[0];
            if (hit)            st.raw <= 1'b1;
            else if (wr.clr_we) st.raw <= 1'b0;
        end
    end
endmodule

// File: rtl/sec_rtc.sv
module sec_rtc
    import sec_rtc_pkg::*;
#(
    parameter int CLK_HZ = 50_000_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              irq
);
    logic              tick;
    rtc_wr_t           wr;
    rtc_state_t        st;
    logic [DATA_W-1:0] count_q;
    logic              raw_q;
    logic              mask_q;

    sec_rtc_prescaler #(.CLK_HZ(CLK_HZ)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    sec_rtc_bus u_bus (
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .pwdata  (pwdata),
        .st      (st),
        .wr      (wr),
        .prdata  (prdata)
    );

    sec_rtc_core u_core (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .wr   (wr),
        .st   (st)
    );

    assign count_q = st.count;
    assign raw_q   = st.raw;
    assign mask_q  = st.mask;
    assign irq     = st.raw & st.mask;
endmodule

// File: rtl/sec_rtc_chk.sv
module sec_rtc_chk
    import sec_rtc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic [ADDR_W-1:0] paddr,
    input logic [DATA_W-1:0] pwdata,
    input logic [DATA_W-1:0] prdata,
    input logic              irq,
    input logic [DATA_W-1:0] count_q,
    input logic              raw_q,
    input logic              mask_q,
    input logic              tick
);
    logic acc_wr, acc_rd, ld_w, mt_w, cl_w;
    assign acc_wr = psel && penable && pwrite;
    assign acc_rd = psel && penable && !pwrite;
    assign ld_w   = acc_wr && (paddr == 12'h008);
    assign mt_w   = acc_wr && (paddr == 12'h004);
    assign cl_w   = acc_wr && (paddr == 12'h01C);

    AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (count_q == '0 && !raw_q && !irq)); // R1
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst) (tick && !ld_w) |=> (count_q == $past(count_q) + 1'b1)); // R2
    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (rst) (!tick && !ld_w) |=> $stable(count_q)); // R2
    AST_LOAD_LANDS: assert property (@(posedge clk) disable iff (rst) ld_w |=> (count_q == $past(pwdata))); // R3
    AST_MASK_ONEBIT: assert property (@(posedge clk) disable iff (rst) (acc_rd && paddr == 12'h010) |-> (prdata[DATA_W-1:1] == '0 && prdata[0] == mask_q)); // R7
    AST_CLEAR_ALONE: assert property (@(posedge clk) disable iff (rst) (cl_w && !tick && !mt_w) |=> !raw_q); // R8
    AST_MIS_MATCHES_PIN: assert property (@(posedge clk) disable iff (rst) (acc_rd && paddr == 12'h018) |-> (prdata == {{(DATA_W-1){1'b0}}, irq})); // R9
    AST_CTRL_ONE: assert property (@(posedge clk) disable iff (rst) (acc_rd && paddr == 12'h00C) |-> (prdata == DATA_W'(1))); // R10
endmodule

bind sec_rtc sec_rtc_chk u_chk (.*);

// File: tb/sec_rtc_bench.sv
module sec_rtc_bench;
    localparam int HZ = 16;

    logic        clk = 1'b0;
    logic        rst;
    logic        psel, penable, pwrite;
    logic [11:0] paddr;
    logic [31:0] pwdata;
    logic [31:0] prdata;
    logic        irq;

    int checks = 0;
    int errors = 0;

    sec_rtc #(.CLK_HZ(HZ)) u_sec_rtc (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq(irq)
    );

    always #10 clk = ~clk;

    // Reference model built from the requirements
    int          m_div;
    logic [31:0] m_count, m_match, m_load;
    logic        m_mask, m_raw;

    always @(posedge clk) begin
        logic        tk, wr, ev;
        logic [31:0] nc, nm;
        if (rst) begin
            m_div = 0; m_count = 0; m_match = 0; m_load = 0; m_mask = 0; m_raw = 0;
        end else begin
            tk = (m_div == HZ - 1);
            m_div = tk ? 0 : m_div + 1;
            wr = psel && penable && pwrite;
            nc = m_count; nm = m_match; ev = 1'b0;
            if (wr && paddr == 12'h008) begin nc = pwdata; m_load = pwdata; ev = 1'b1; end
            else if (tk) begin nc = m_count + 1; ev = 1'b1; end
            if (wr && paddr == 12'h004) begin nm = pwdata; ev = 1'b1; end
            if (wr && paddr == 12'h010) m_mask = pwdata[0];
            if (ev && nc == nm) m_raw = 1'b1;
            else if (wr && paddr == 12'h01C) m_raw = 1'b0;
            m_count = nc; m_match = nm;
        end
    end

    function automatic logic [31:0] exp_read(input logic [11:0] a);
        logic [7:0] ids [8];
        ids = '{8'h31, 8'h10, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        if (a[11:5] == 7'h7F) return {24'h0, ids[a[4:2]]};
        if (a[11:5] != 7'h00) return 32'h0;
        case (a[4:2])
            3'd0: return m_count;
            3'd1: return m_match;
            3'd2: return m_load;
            3'd3: return 32'h1;
            3'd4: return {31'h0, m_mask};
            3'd5: return {31'h0, m_raw};
            3'd6: return {31'h0, m_raw & m_mask};
            default: return 32'h0;
        endcase
    endfunction

    function automatic string req_of(input logic [11:0] a);
        if (a[11:5] == 7'h7F) return "R11";
        if (a[11:5] != 7'h00) return "R12";
        case (a[4:2])
            3'd0: return "R2";
            3'd1: return "R5";
            3'd2: return "R3";
            3'd3: return "R10";
            3'd4: return "R7";
            3'd5: return "R5";
            3'd6: return "R9";
            default: return "R12";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic apb_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_read(input logic [11:0] a, input string tag, output logic [31:0] v);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
        @(negedge clk);
        penable = 1'b1;
        #2;
        v = prdata;
        check(tag, v, exp_read(a));
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic read_chk(input logic [11:0] a, input string tag);
        logic [31:0] v;
        apb_read(a, tag, v);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual run still going, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v0, v1;
        logic [11:0] a;
        logic [31:0] d;
        void'($urandom(32'h5EC0_0A1A));
        psel = 0; penable = 0; pwrite = 0; paddr = 0; pwdata = 0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        #2;
        check("R1 irq in reset", {31'h0, irq}, 32'h0);
        check("R1 count in reset", prdata, 32'h0);
        @(negedge clk);
        rst = 1'b0;
        // R1 register values right after release
        read_chk(12'h000, "R1 count");
        read_chk(12'h004, "R1 match");
        read_chk(12'h008, "R1 load");
        read_chk(12'h010, "R1 mask");
        read_chk(12'h014, "R1 raw");

        // R2 exact period: three enables over 3*HZ edges
        apb_write(12'h004, 32'h8000_0000);
        apb_read(12'h000, "R2 start", v0);
        repeat (3 * HZ - 3) @(negedge clk);
        apb_read(12'h000, "R2 end", v1);
        check("R2 three seconds", v1 - v0, 32'd3);

        // R3 load and resume
        apb_write(12'h008, 32'd1000);
        read_chk(12'h008, "R3 load readback");
        read_chk(12'h000, "R3 count after load");
        repeat (2 * HZ) @(negedge clk);
        read_chk(12'h000, "R3 count continues");

        // R6 load that equals the alarm value fires at once
        apb_write(12'h004, 32'd77);
        apb_write(12'h01C, 32'h0);
        apb_write(12'h008, 32'd77);
        read_chk(12'h014, "R6 raw set by load");
        check("R6 raw direct", {31'h0, m_raw}, 32'h1);
        // R9 irq gated by enable bit
        check("R9 irq masked off", {31'h0, irq}, 32'h0);
        apb_write(12'h010, 32'hFFFF_FFFF);
        read_chk(12'h010, "R7 mask keeps bit0");
        check("R9 irq on", {31'h0, irq}, 32'h1);
        read_chk(12'h018, "R9 masked status");
        // R8 clear with arbitrary data
        apb_write(12'h01C, 32'hA5A5_0000);
        read_chk(12'h014, "R8 raw cleared");
        check("R8 irq low", {31'h0, irq}, {31'h0, m_raw & m_mask});

        // R4 wrap and alarm on 0
        apb_write(12'h004, 32'h0);
        apb_write(12'h008, 32'hFFFF_FFFE);
        apb_write(12'h01C, 32'h1);
        repeat (2 * HZ + 2) @(negedge clk);
        read_chk(12'h000, "R4 count wrapped");
        read_chk(12'h014, "R4 alarm at wrap");
        check("R4 model raw", {31'h0, m_raw}, 32'h1);

        // R10 writes with no effect
        apb_write(12'h00C, 32'h0);
        apb_write(12'h000, 32'hDEAD_BEEF);
        apb_write(12'h014, 32'h0);
        apb_write(12'h018, 32'h0);
        read_chk(12'h00C, "R10 control");
        read_chk(12'h000, "R10 count untouched");
        read_chk(12'h014, "R10 raw untouched");

        // R11 identification bytes, R12 unmapped
        for (int i = 0; i < 8; i++) read_chk(12'hFE0 + 12'(i * 4), "R11 id byte");
        read_chk(12'h01C, "R12 clear reads 0");
        read_chk(12'h020, "R12 unmapped");
        read_chk(12'h800, "R12 unmapped");
        read_chk(12'hFDC, "R12 unmapped");

        // Random traffic against the model
        for (int n = 0; n < 600; n++) begin
            a = 12'($urandom_range(0, 7) * 4);
            if ($urandom_range(0, 9) == 0) a = 12'hFE0 + 12'($urandom_range(0, 7) * 4);
            case ($urandom_range(0, 3))
                0: d = m_count + $urandom_range(0, 2);
                1: d = 32'hFFFF_FFFF - $urandom_range(0, 2);
                default: d = $urandom;
            endcase
            if ($urandom_range(0, 2) == 0) apb_write(a, d);
            else read_chk(a, req_of(a));
            if ($urandom_range(0, 4) == 0) repeat ($urandom_range(1, HZ)) @(negedge clk);
        end
        check("R9 irq final", {31'h0, irq}, {31'h0, m_raw & m_mask});

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule